// File: doc/BRIEF.md
# ADC Result Register Formatter

This block holds the most recent 10-bit conversion result from an analog-to-digital converter. A processor reads it as two read-only 8-bit registers: a high byte and a low byte. A 2-bit mode input selects one of four alignments:

- truncated to 8 bits;
- right aligned;
- left aligned;
- left aligned with the top bit inverted, which gives a two's-complement view of an offset-binary sample.

The alignment is applied when the value is read, not when it is stored. Changing the mode therefore changes what the registers return without waiting for a new conversion.

A single lock flag keeps the two bytes coherent. A read of the high byte sets the flag. While it is set, completed conversions are discarded, so the low byte the processor reads next belongs to the same sample. A read of the low byte clears the flag.

Read data is combinational from the address select, the mode and the stored result. The read strobe only acts on the lock.

Top module: `adc_result_fmt`

## Requirements
- R1: After reset the stored result is zero, so both the high byte (address 0) and the low byte (address 1) read 8'h00 in every mode.
- R2: With mode 2'b00 (truncated), the high byte reads 8'h00 and the low byte reads result bits 9..2.
- R3: With mode 2'b01 (right aligned), the high byte reads {6'b0, bits 9..8} and the low byte reads bits 7..0.
- R4: With mode 2'b10 (left aligned), the high byte reads bits 9..2 and the low byte reads {bits 1..0, 6'b0}.
- R5: With mode 2'b11 (signed left aligned), the high byte reads {~bit 9, bits 8..2} and the low byte matches R4.
- R6: While unlocked, a cycle with conv_done_i high stores conv_data_i. The new value is readable from the following cycle.
- R7: A cycle with rd_en_i high and rd_addr_i = 0 sets the lock. While the lock is set, conversions are dropped and the stored result does not change.
- R8: A cycle with rd_en_i high and rd_addr_i = 1 clears the lock. A conversion that completes in that same cycle is stored.
- R9: A low-byte read while unlocked has no side effect: the lock stays clear and the next conversion is stored.
- R10: A change of mode_i changes the read value at once, with no new conversion.
- R11: A conversion that completes in the same cycle as a high-byte read, while unlocked, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| conv_done_i | input | 1 | One-cycle strobe: a conversion has finished |
| conv_data_i | input | 10 | Conversion result, valid with conv_done_i |
| mode_i | input | 2 | Alignment mode: 00 truncated, 01 right, 10 left, 11 signed left |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 1 | Register select: 0 high byte, 1 low byte |
| rd_data_o | output | 8 | Formatted byte for the selected register |

## Verification
The assertions assume the processor issues at most one read per cycle, so a high read and a low read never fall in the same cycle. They also assume conv_done_i is a single-cycle pulse whose data is valid only in that cycle. The bench drives every strobe for exactly one cycle, on the falling edge, and samples on the next falling edge. It changes the address and mode only between strobes. Collisions are produced on purpose only where R8 and R11 define the outcome: a strobe landing with a high read, and a strobe landing with a low read.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  typedef enum logic [1:0] {
    MODE_TRUNC = 2'b00,
    MODE_RIGHT = 2'b01,
    MODE_LEFT  = 2'b10,
    MODE_SIGN  = 2'b11
  } align_mode_e;

  localparam logic ADDR_HI = 1'b0;
  localparam logic ADDR_LO = 1'b1;
endpackage

// File: rtl/adc_fmt_capture.sv
module adc_fmt_capture #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  input  logic              rd_hi_i,
  input  logic              rd_lo_i,
  output logic [DATA_W-1:0] result_o,
  output logic              lock_o
);
  logic [DATA_W-1:0] result_q;
  logic              lock_q;
  logic              load;

  // low read releases the lock in the same cycle; high read blocks a colliding load
  assign load = conv_done_i && !rd_hi_i && (!lock_q || rd_lo_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      lock_q   <= 1'b0;
    end else begin
      if (load) result_q <= conv_data_i;
      if (rd_hi_i)      lock_q <= 1'b1;
      else if (rd_lo_i) lock_q <= 1'b0;
    end
  end

  assign result_o = result_q;
  assign lock_o   = lock_q;

  a_r6_load_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && !lock_q && !rd_hi_i) |=> (result_q == $past(conv_data_i)));
  a_r7_lock_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi_i |=> lock_q);
  a_r7_hold_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !rd_lo_i) |=> $stable(result_q));
  a_r8_lock_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lo_i && !rd_hi_i) |=> !lock_q);
  a_r11_collide_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi_i && !lock_q) |=> $stable(result_q));
endmodule

// File: rtl/adc_fmt_align.sv
module adc_fmt_align
  import adc_fmt_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] result_i,
  input  align_mode_e       mode_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o
);
  localparam int TAIL_W = DATA_W - BYTE_W;   // bits below the top byte
  localparam int PAD_W  = BYTE_W - TAIL_W;   // zero fill in split bytes

  logic [BYTE_W-1:0] top_byte;
  logic [BYTE_W-1:0] right_hi;
  logic [BYTE_W-1:0] left_lo;

  assign top_byte = result_i[DATA_W-1 -: BYTE_W];
  assign right_hi = {{PAD_W{1'b0}}, result_i[DATA_W-1:BYTE_W]};
  assign left_lo  = {result_i[TAIL_W-1:0], {PAD_W{1'b0}}};

  always_comb begin
    unique case (mode_i)
      MODE_TRUNC: begin hi_o = '0;       lo_o = top_byte;                 end
      MODE_RIGHT: begin hi_o = right_hi; lo_o = result_i[BYTE_W-1:0];     end
      MODE_LEFT:  begin hi_o = top_byte; lo_o = left_lo;                  end
      default:    begin hi_o = {~top_byte[BYTE_W-1], top_byte[BYTE_W-2:0]};
                        lo_o = left_lo;                                   end
    endcase
  end

  always_comb begin
    a_r2_trunc_hi_zero: assert (mode_i != MODE_TRUNC || hi_o == '0);
    a_r5_sign_flip: assert (mode_i != MODE_SIGN || hi_o[BYTE_W-1] != result_i[DATA_W-1]);
  end
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
  import adc_fmt_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  input  logic [1:0]        mode_i,
  input  logic              rd_en_i,
  input  logic              rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] result;
  logic              lock;
  logic              rd_hi, rd_lo;
  logic [BYTE_W-1:0] hi_byte, lo_byte;

  assign rd_hi = rd_en_i && (rd_addr_i == ADDR_HI);
  assign rd_lo = rd_en_i && (rd_addr_i == ADDR_LO);

  adc_fmt_capture #(.DATA_W(DATA_W)) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .conv_done_i(conv_done_i),
    .conv_data_i(conv_data_i),
    .rd_hi_i    (rd_hi),
    .rd_lo_i    (rd_lo),
    .result_o   (result),
    .lock_o     (lock)
  );

  adc_fmt_align #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_align (
    .result_i(result),
    .mode_i  (align_mode_e'(mode_i)),
    .hi_o    (hi_byte),
    .lo_o    (lo_byte)
  );

  assign rd_data_o = (rd_addr_i == ADDR_HI) ? hi_byte : lo_byte;

  a_r9_lo_read_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lo && !lock) |=> !lock);
endmodule

// File: tb/adc_result_fmt_tb_top.sv
module adc_result_fmt_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_done = 1'b0;
  logic [9:0] conv_data = '0;
  logic [1:0] mode = 2'b00;
  logic       rd_en = 1'b0;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  adc_result_fmt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .conv_done_i(conv_done), .conv_data_i(conv_data),
    .mode_i(mode), .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  function automatic logic [7:0] ref_byte(input logic [1:0] m, input logic [9:0] d, input logic hi);
    case (m)
      2'b00: ref_byte = hi ? 8'h00 : d[9:2];
      2'b01: ref_byte = hi ? {6'b0, d[9:8]} : d[7:0];
      2'b10: ref_byte = hi ? d[9:2] : {d[1:0], 6'b0};
      default: ref_byte = hi ? {~d[9], d[8:2]} : {d[1:0], 6'b0};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // observe a byte without a read strobe
  task automatic peek(input logic a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b0; rd_addr = a;
    #1 v = rd_data;
  endtask

  // one-cycle read strobe; value sampled during the strobe cycle
  task automatic bus_read(input logic a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic convert(input logic [9:0] d);
    @(negedge clk);
    conv_done = 1'b1; conv_data = d;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic check_all_modes(input string tag, input logic [9:0] d);
    logic [7:0] v;
    for (int m = 0; m < 4; m++) begin
      mode = m[1:0];
      peek(1'b0, v); chk(tag, v, ref_byte(m[1:0], d, 1'b1));
      peek(1'b1, v); chk(tag, v, ref_byte(m[1:0], d, 1'b0));
    end
  endtask

  task automatic t_reset();
    check_all_modes("R1 reset zero", 10'h000);
  endtask

  task automatic t_formats();
    convert(10'h2D6);
    check_all_modes("R6 load / R2 R3 R4 R5 formats", 10'h2D6);
    convert(10'h13B);
    check_all_modes("R2 R3 R4 R5 formats second pattern", 10'h13B);
  endtask

  task automatic t_mode_change();
    logic [7:0] v;
    mode = 2'b10; peek(1'b0, v); chk("R10 mode left", v, 8'h4E);
    mode = 2'b11; peek(1'b0, v); chk("R10 mode sign", v, 8'hCE);
  endtask

  task automatic t_lock_drop();
    logic [7:0] v;
    mode = 2'b10;
    bus_read(1'b0, v); chk("R7 high read", v, 8'h4E);
    convert(10'h155);
    convert(10'h3AA);
    peek(1'b0, v); chk("R7 dropped while locked hi", v, 8'h4E);
    bus_read(1'b1, v); chk("R7 low coherent", v, 8'hC0);
    convert(10'h155);
    peek(1'b0, v); chk("R8 unlocked after low read", v, 8'h55);
  endtask

  task automatic t_same_cycle_clear();
    logic [7:0] v;
    mode = 2'b01;
    bus_read(1'b0, v); chk("R7 high read right", v, 8'h01);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 1'b1; conv_done = 1'b1; conv_data = 10'h3FF;
    @(negedge clk);
    rd_en = 1'b0; conv_done = 1'b0;
    peek(1'b1, v); chk("R8 same-cycle load lo", v, 8'hFF);
    peek(1'b0, v); chk("R8 same-cycle load hi", v, 8'h03);
    convert(10'h201);
    peek(1'b1, v); chk("R8 lock cleared", v, 8'h01);
  endtask

  task automatic t_lo_unlocked();
    logic [7:0] v;
    mode = 2'b01;
    bus_read(1'b1, v); chk("R9 low read unlocked", v, 8'h01);
    convert(10'h0AA);
    peek(1'b1, v); chk("R9 next conversion stored", v, 8'hAA);
  endtask

  task automatic t_collide_hi();
    logic [7:0] v;
    mode = 2'b01;
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 1'b0; conv_done = 1'b1; conv_data = 10'h123;
    #1 chk("R11 high read value", rd_data, 8'h00);
    @(negedge clk);
    rd_en = 1'b0; conv_done = 1'b0;
    peek(1'b1, v); chk("R11 collision dropped", v, 8'hAA);
    bus_read(1'b1, v); chk("R11 low read", v, 8'hAA);
    convert(10'h123);
    peek(1'b1, v); chk("R11 later conversion stored", v, 8'h23);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_formats();
    t_mode_change();
    t_lock_drop();
    t_same_cycle_clear();
    t_lo_unlocked();
    t_collide_hi();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule